// File: doc/BRIEF.md
# Sequential Shift-Subtract Integer Divider

This block divides one 32-bit integer by another over several clocks and returns both the quotient and the remainder. A single wide shift register does all the work. At the start its upper part is cleared and its lower part takes the dividend. Each clock tries one subtraction of the divisor from the upper part. After the last step, the lower half holds the quotient and the upper part, shifted back by one, holds the remainder.

A one-cycle `start` pulse launches an operation, but only while the unit is idle. `busy` stays high for the whole run. `done` pulses for one cycle when `lo` (quotient) and `hi` (remainder) become valid, and both outputs keep their values until the next operation completes. A select input picks signed or unsigned operation. In signed mode the core divides magnitudes, and the signs are applied to the results afterwards. Division by zero and quotient overflow raise no flag. Software is expected to screen for them.

Top module: `seq_divider`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are 0 and `hi` and `lo` are 0.
- R2: A `start` seen while idle is accepted on that rising edge. `busy` is high from the next cycle onward. `done` is high in the cycle after the 34th rising edge that follows the accepting edge, and `busy` is low in that same cycle. `busy` and `done` are never high together.
- R3: With `is_signed` = 0, both operands are unsigned, and `lo` = dividend / divisor and `hi` = dividend mod divisor.
- R4: With `is_signed` = 1, both operands are two's complement. The quotient is truncated toward zero and is negated when the operand signs differ. A non-zero remainder carries the sign of the dividend (-7/2 gives -3 rem -1; 7/-2 gives -3 rem 1).
- R5: In signed mode, the value 0x80000000 is treated as magnitude 2^31. For example, 0x80000000 / -1 gives `lo` = 0x80000000 and `hi` = 0.
- R6: A zero divisor takes the normal cycle count. It gives an unsigned quotient magnitude of 0xFFFFFFFF and a remainder equal to the dividend, with the R4 sign rules applied afterwards, and no flag is raised.
- R7: A `start` pulse while `busy` is high is ignored. The running operation completes with its own results, and no extra `done` follows.
- R8: `done` is high for exactly one cycle per operation. `hi` and `lo` change only in the cycle that `done` is high.
- R9: Unsigned divisors of 2^31 or more give correct results. This holds even when the shifted partial remainder exceeds 32 bits.
- R10: At completion, the remainder magnitude is smaller than the divisor magnitude whenever the divisor is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled when start is accepted |
| divisor | input | 32 | Divisor, sampled when start is accepted |
| lo | output | 32 | Quotient of the last completed operation |
| hi | output | 32 | Remainder of the last completed operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |

## Verification
Two situations are hard to reach with ordinary operands.

The first is a partial remainder that spills past 32 bits. It appears only with unsigned divisors at or above 2^31 together with large dividends, so the stimulus includes hand-picked cases such as 0xFFFFFFFE / 0x80000000 and 0xFFFFFFFF / 0xFFFFFFFF.

The second is a second `start` arriving mid-run with different operands. The bench drives one part way through an operation. The scoreboard then flags any extra `done` or any result that does not belong to the first request.

The most negative dividend is also covered, both with a -1 divisor and with a zero divisor.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PRESHIFT = 2'd1,
    ST_ITER     = 2'd2,
    ST_FIX      = 2'd3
  } div_state_e;

  typedef struct packed {
    logic neg_quo;
    logic neg_rem;
  } sign_fix_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         signed_mode,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output sign_fix_t    fix
);

  // Magnitude of a value; the most negative input maps to 2^(W-1) unsigned.
  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic sgn);
    magnitude = (sgn && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  assign mag_a = magnitude(op_a, signed_mode);
  assign mag_b = magnitude(op_b, signed_mode);

  assign fix.neg_quo = signed_mode && (op_a[W-1] ^ op_b[W-1]);
  assign fix.neg_rem = signed_mode && op_a[W-1];

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_ev,
  output logic preshift_ev,
  output logic iter_ev,
  output logic last_iter,
  output logic fix_ev,
  output logic busy
);

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(W - 1);

  div_state_e       state, state_nxt;
  logic [CNT_W-1:0] cnt;

  assign busy        = (state != ST_IDLE);
  assign load_ev     = start && !busy;
  assign preshift_ev = (state == ST_PRESHIFT);
  assign iter_ev     = (state == ST_ITER);
  assign fix_ev      = (state == ST_FIX);
  assign last_iter   = iter_ev && (cnt == LAST_CNT);

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:     if (start) state_nxt = ST_PRESHIFT;
      ST_PRESHIFT: state_nxt = ST_ITER;
      ST_ITER:     if (cnt == LAST_CNT) state_nxt = ST_FIX;
      ST_FIX:      state_nxt = ST_IDLE;
      default:     state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nxt;
      if (preshift_ev)  cnt <= '0;
      else if (iter_ev) cnt <= cnt + 1'b1;
    end
  end

  // R7: a start while running must not restart or end the run early.
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fix_ev && start) |=> busy);

  // R2: completion follows only the final iteration.
  p_fix_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fix_ev |-> $past(last_iter));

  // R2: a new run always begins with the single pre-shift.
  p_load_to_preshift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> preshift_ev);

endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_ev,
  input  logic         preshift_ev,
  input  logic         iter_ev,
  input  logic         fix_ev,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  output logic [W-1:0] quo_mag,
  output logic [W-1:0] rem_mag
);

  localparam int ACC_W = 2 * W + 1;  // extra top bit holds the spill of the partial remainder

  logic [ACC_W-1:0] acc;
  logic [W-1:0]     dvs;
  logic [W+1:0]     trial;
  logic             trial_neg;

  // Trial subtraction of the divisor from the (W+1)-bit upper part.
  function automatic logic [W+1:0] trial_sub(input logic [W:0] upper, input logic [W-1:0] d);
    trial_sub = {1'b0, upper} - {2'b00, d};
  endfunction

  // One restore-or-keep step merged with the left shift.
  function automatic logic [ACC_W-1:0] step(input logic [ACC_W-1:0] a, input logic [W+1:0] t);
    if (t[W+1]) step = {a[ACC_W-2:0], 1'b0};
    else        step = {t[W-1:0], a[W-1:0], 1'b1};
  endfunction

  assign trial     = trial_sub(acc[ACC_W-1:W], dvs);
  assign trial_neg = trial[W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      dvs <= '0;
    end else if (load_ev) begin
      acc <= {{(W+1){1'b0}}, mag_a};
      dvs <= mag_b;
    end else if (preshift_ev) begin
      acc <= {acc[ACC_W-2:0], 1'b0};
    end else if (iter_ev) begin
      acc <= step(acc, trial);
    end
  end

  // Final correction: only the upper part moves back right by one.
  assign rem_mag = acc[ACC_W-1:W+1];
  assign quo_mag = acc[W-1:0];

  // R9: a kept difference always fits back into W bits.
  p_keep_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_ev && !trial_neg) |-> !trial[W]);

  // R10: the final remainder magnitude is below a non-zero divisor.
  p_rem_below_divisor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_ev && dvs != '0) |-> (rem_mag < dvs));

  // R6: a zero divisor never restores, so every quotient bit is one.
  p_zero_div_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_ev && dvs == '0) |-> (quo_mag == '1));

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [31:0]  dividend,
  input  logic [31:0]  divisor,
  output logic [31:0]  lo,
  output logic [31:0]  hi,
  output logic         busy,
  output logic         done
);

  logic [W-1:0] mag_a, mag_b, quo_mag, rem_mag;
  sign_fix_t    fix_in, fix_q;
  logic         load_ev, preshift_ev, iter_ev, last_iter, fix_ev;
  logic [W-1:0] lo_q, hi_q;
  logic         done_q;

  function automatic logic [W-1:0] apply_sign(input logic [W-1:0] v, input logic neg);
    apply_sign = neg ? (~v + 1'b1) : v;
  endfunction

  div_operand_prep #(.W(W)) u_prep (
    .op_a        (dividend[W-1:0]),
    .op_b        (divisor[W-1:0]),
    .signed_mode (is_signed),
    .mag_a       (mag_a),
    .mag_b       (mag_b),
    .fix         (fix_in)
  );

  div_ctrl #(.W(W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .load_ev     (load_ev),
    .preshift_ev (preshift_ev),
    .iter_ev     (iter_ev),
    .last_iter   (last_iter),
    .fix_ev      (fix_ev),
    .busy        (busy)
  );

  div_datapath #(.W(W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_ev     (load_ev),
    .preshift_ev (preshift_ev),
    .iter_ev     (iter_ev),
    .fix_ev      (fix_ev),
    .mag_a       (mag_a),
    .mag_b       (mag_b),
    .quo_mag     (quo_mag),
    .rem_mag     (rem_mag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (load_ev) fix_q <= fix_in;
      done_q <= fix_ev;
      if (fix_ev) begin
        lo_q <= apply_sign(quo_mag, fix_q.neg_quo);
        hi_q <= apply_sign(rem_mag, fix_q.neg_rem);
      end
    end
  end

  assign lo   = lo_q;
  assign hi   = hi_q;
  assign done = done_q;

  // R8: done lasts a single cycle.
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: results hold whenever no completion is signalled.
  p_hold_results_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(lo) && $stable(hi)));

  // R2: busy and done are exclusive.
  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R4: a non-zero remainder of a negative signed dividend is negative.
  p_rem_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fix_q.neg_rem && hi != '0) |-> hi[W-1]);

endmodule

// File: tb/seq_divider_tb.sv
module seq_divider_tb;

  localparam int W = 32;
  localparam int LATENCY = W + 3;  // negedges counted from the one after the accepting edge

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic [31:0] lo, hi;
  logic        busy, done;

  always #10 clk = ~clk;  // 50 MHz

  seq_divider u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor),
    .lo(lo), .hi(hi), .busy(busy), .done(done)
  );

  typedef struct {
    logic [31:0] q;
    logic [31:0] r;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   n_checks = 0;
  int   n_fail = 0;
  int   n_done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Reference model in 64-bit arithmetic, from the requirements.
  function automatic void model(input logic [31:0] a, input logic [31:0] b, input logic sg,
                                output logic [31:0] q, output logic [31:0] r);
    longint sa, sdv, ma, mb, qm, rm;
    logic [63:0] t;
    sa  = sg ? longint'($signed(a)) : longint'({32'b0, a});
    sdv = sg ? longint'($signed(b)) : longint'({32'b0, b});
    ma  = (sa < 0) ? -sa : sa;
    mb  = (sdv < 0) ? -sdv : sdv;
    if (mb == 0) begin qm = 64'hFFFF_FFFF; rm = ma; end
    else begin qm = ma / mb; rm = ma % mb; end
    t = ((sa < 0) != (sdv < 0)) ? 64'(-qm) : 64'(qm);
    q = t[31:0];
    t = (sa < 0) ? 64'(-rm) : 64'(rm);
    r = t[31:0];
  endfunction

  // Monitor: pops the scoreboard on every completion.
  always @(negedge clk) begin
    if (rst_n && done === 1'b1) begin
      n_done++;
      if (sbq.size() == 0) begin
        chk(1'b0, "R7 unexpected done", lo, 32'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(lo === e.q, {e.tag, " quotient"}, lo, e.q);
        chk(hi === e.r, {e.tag, " remainder"}, hi, e.r);
      end
    end
  end

  // Driver: one operation, with latency and hold checks (R2, R8).
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic sg, input string tag);
    exp_t e;
    int   cyc;
    model(a, b, sg, e.q, e.r);
    e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    dividend = a; divisor = b; is_signed = sg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy === 1'b1, "R2 busy after start", {31'b0, busy}, 32'h1);
    while (done !== 1'b1) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == LATENCY, "R2 latency", cyc, LATENCY);
    chk(busy === 1'b0, "R2 busy low with done", {31'b0, busy}, 32'h0);
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", {31'b0, done}, 32'h0);
    chk(lo === e.q && hi === e.r, "R8 results held", lo, e.q);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [31:0] rs;
    exp_t        e1;
    int          done_before;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0 && done === 1'b0, "R1 flags in reset", {30'b0, busy, done}, 32'h0);
    chk(lo === 32'h0 && hi === 32'h0, "R1 results in reset", lo ^ hi, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && lo === 32'h0 && hi === 32'h0, "R1 after release", lo, 32'h0);

    // R3: unsigned
    run_op(32'd100, 32'd7, 1'b0, "R3 100/7");
    run_op(32'd7, 32'd2, 1'b0, "R3 7/2");
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0, "R3 max/1");
    run_op(32'd5, 32'hFFFF_FFFF, 1'b0, "R3 small/max");
    run_op(32'h1234_5678, 32'h0000_1000, 1'b0, "R3 pow2 divisor");
    // R9: wide divisors
    run_op(32'hFFFF_FFFE, 32'h8000_0000, 1'b0, "R9 big/2^31");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R9 max/max");
    run_op(32'hF000_0001, 32'hC000_0000, 1'b0, "R9 spill");
    // R4: signed
    run_op(-32'sd7, 32'sd2, 1'b1, "R4 -7/2");
    run_op(32'sd7, -32'sd2, 1'b1, "R4 7/-2");
    run_op(-32'sd7, -32'sd2, 1'b1, "R4 -7/-2");
    run_op(32'sd6, -32'sd3, 1'b1, "R4 exact negative");
    // R5: most negative value
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R5 min/-1");
    run_op(32'h8000_0000, 32'd2, 1'b1, "R5 min/2");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, "R5 min/min");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0, "R3 2^31 unsigned");
    // R6: zero divisor
    run_op(32'd12345, 32'd0, 1'b0, "R6 unsigned /0");
    run_op(-32'sd9, 32'd0, 1'b1, "R6 signed neg /0");
    run_op(32'h8000_0000, 32'd0, 1'b1, "R6 min /0");
    run_op(32'd0, 32'd0, 1'b0, "R6 0/0");

    // R7: start while busy is ignored
    model(32'd1000, 32'd33, 1'b0, e1.q, e1.r);
    e1.tag = "R7 first op kept";
    sbq.push_back(e1);
    done_before = n_done;
    @(negedge clk);
    dividend = 32'd1000; divisor = 32'd33; is_signed = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    dividend = 32'd77; divisor = 32'd5; is_signed = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (80) @(negedge clk);
    chk(n_done == done_before + 1, "R7 single done", n_done, done_before + 1);
    chk(busy === 1'b0, "R7 idle afterwards", {31'b0, busy}, 32'h0);
    chk(lo === e1.q && hi === e1.r, "R8 hold after idle", lo, e1.q);

    // Mixed pseudo-random operands (R3, R4)
    rs = 32'hACE1_2468;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      a = rs;
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      b = rs >> (i % 28);
      run_op(a, b, i[0], i[0] ? "R4 random" : "R3 random");
    end

    repeat (5) @(negedge clk);
    chk(sbq.size() == 0, "R8 every op completed", sbq.size(), 32'h0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule